// File: doc/BRIEF.md
# Blit Tail Mask and Span Counter

This block sits beside the write path of a planar blitter and decides, for every write into the destination, which of the 16 bits in the word may change. It keeps track of how many bits of the current blit are still to be written. As the end of the span approaches, it narrows the write mask so that nothing past the last pixel is touched. The first word of a span may begin part-way into a word, at the destination bit offset. That word therefore uses less of the span, and its tail mask is moved to line up with that offset.

Software loads a 12-bit length, and the span is that value plus one bits. Each counted write (a full word, or a single byte lane) reduces the remaining count. When the count runs out, the block reloads the span from the stored length, so the next run of writes starts a fresh span with no further set-up. A separate strobe marks the span as primed, for example after a source pre-fetch. That mark lasts until the span is reloaded.

Top module: `blit_edge_ctl`

## Requirements
- R1: A pulse on `len_wr` stores `len_val`, sets the remaining count to `len_val`+1, sets `first_word` and clears `primed`, all visible the cycle after. It takes priority over any other strobe in the same cycle.
- R2: While the remaining count is 16 or more, `wmask` equals `mask_reg` ANDed with the lane expansion. Bits 7:0 follow `lane_en[0]` and bits 15:8 follow `lane_en[1]`.
- R3: Ascending direction (`dir_desc`=0), count n below 16, not the first word: `wmask` keeps only bits 0 to n-1 of the base mask.
- R4: Descending direction (`dir_desc`=1), count n below 16, not the first word: `wmask` keeps only bits 16-n to 15 of the base mask.
- R5: On the first word with count n below 16, the tail mask is shifted by `dst_off`. Ascending keeps bits `dst_off` to `dst_off`+n-1, clipped at bit 15. Descending keeps bits 16-n-`dst_off` to 15-`dst_off`, clipped at bit 0.
- R6: A byte-wide counted write (`lane_en` not 2'b11) reduces the count by 8-(`dst_off` mod 8) on the first word and by 8 on later words.
- R7: A full-word counted write (`lane_en`=2'b11) reduces the count by 16-`dst_off` on the first word and by 16 on later words.
- R8: When a counted write brings the count to zero or below, the count reloads to the stored length plus one, `first_word` sets and `primed` clears on the next cycle. `done` is high for exactly that one cycle.
- R9: A counted write that does not end the span clears `first_word` on the next cycle.
- R10: `prime_stb` sets `primed` on the next cycle and leaves the count unchanged. A reload or a length load in the same cycle takes priority and clears it.
- R11: After reset the stored length is 0, the count is 1, `first_word`=1, `primed`=0 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_wr | input | 1 | Load strobe for the span length |
| len_val | input | 12 | Span length minus one |
| dir_desc | input | 1 | 0 = ascending bit order, 1 = descending |
| dst_off | input | 4 | Destination bit offset of the first word |
| mask_reg | input | 16 | Base write mask |
| lane_en | input | 2 | Byte lanes enabled by the current access |
| wr_stb | input | 1 | Counted write to the destination |
| prime_stb | input | 1 | Marks the span as primed |
| wmask | output | 16 | Final write mask for the current access |
| first_word | output | 1 | Next counted write is the first of its span |
| primed | output | 1 | Span has been primed |
| done | output | 1 | One-cycle pulse after the write that ended a span |

## Verification
`wmask` is combinational from the inputs and the current count, so the bench checks it 1 ns after it drives an access, before the clock edge that uses that access. `first_word`, `primed` and `done` are registered and so change one edge after the strobe that causes them, as does the count behind `wmask`. The bench's reference model is updated at that same edge, and the next comparison runs after it. Every step therefore compares the registered results against the model's state from the edge before, and `wmask` against the values driven for the current step.

// File: rtl/blit_pkg.sv
package blit_pkg;
  localparam int unsigned BLIT_DATA_W = 16;
  localparam int unsigned BLIT_LEN_W  = 12;
  localparam int unsigned BLIT_LANE_W = 8;

  typedef enum logic {
    BLIT_ASC  = 1'b0,
    BLIT_DESC = 1'b1
  } blit_dir_e;
endpackage

// File: rtl/blit_len_ctr.sv
module blit_len_ctr #(
  parameter int unsigned LEN_W  = blit_pkg::BLIT_LEN_W,
  parameter int unsigned DATA_W = blit_pkg::BLIT_DATA_W,
  parameter int unsigned LANE_W = blit_pkg::BLIT_LANE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      len_wr,
  input  logic [LEN_W-1:0]          len_val,
  input  logic                      wr_stb,
  input  logic                      prime_stb,
  input  logic                      byte_acc,
  input  logic [$clog2(DATA_W)-1:0] dst_off,
  output logic                      first_q,
  output logic                      primed_q,
  output logic                      done_q,
  output logic                      cnt_small,
  output logic [$clog2(DATA_W)-1:0] cnt_low
);
  localparam int unsigned CNT_W = LEN_W + 2;
  localparam int unsigned OFF_W = $clog2(DATA_W);

  // Bits consumed by one counted write.
  function automatic logic signed [CNT_W-1:0] step_amt(
    input logic first, input logic is_byte, input logic [OFF_W-1:0] off);
    int a;
    if (is_byte) a = first ? int'(LANE_W) - (int'(off) % int'(LANE_W)) : int'(LANE_W);
    else         a = first ? int'(DATA_W) - int'(off) : int'(DATA_W);
    return CNT_W'(a);
  endfunction

  logic [LEN_W-1:0]        len_q;
  logic signed [CNT_W-1:0] cnt_q;
  logic signed [CNT_W-1:0] span_load;
  logic signed [CNT_W-1:0] span_reload;
  logic signed [CNT_W-1:0] dec_amt;
  logic signed [CNT_W-1:0] cnt_after;
  logic                    load_ev;
  logic                    count_ev;
  logic                    exhaust_ev;

  assign load_ev     = len_wr;
  assign count_ev    = wr_stb && !len_wr;
  assign span_load   = $signed({2'b00, len_val}) + CNT_W'(1);
  assign span_reload = $signed({2'b00, len_q}) + CNT_W'(1);
  assign dec_amt     = step_amt(first_q, byte_acc, dst_off);
  assign cnt_after   = cnt_q - dec_amt;
  assign exhaust_ev  = count_ev && (cnt_after <= 0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q    <= '0;
      cnt_q    <= CNT_W'(1);
      first_q  <= 1'b1;
      primed_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= exhaust_ev;
      if (load_ev) begin
        len_q    <= len_val;
        cnt_q    <= span_load;
        first_q  <= 1'b1;
        primed_q <= 1'b0;
      end else if (exhaust_ev) begin
        cnt_q    <= span_reload;
        first_q  <= 1'b1;
        primed_q <= 1'b0;
      end else begin
        if (count_ev) begin
          cnt_q   <= cnt_after;
          first_q <= 1'b0;
        end
        if (prime_stb) primed_q <= 1'b1;
      end
    end
  end

  assign cnt_small = (cnt_q < $signed(CNT_W'(DATA_W)));
  assign cnt_low   = cnt_q[OFF_W-1:0];

  // R1
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> (first_q && !primed_q && !done_q));
  // R8
  reload_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exhaust_ev |=> (first_q && !primed_q && done_q));
  // R8
  cnt_positive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q > 0);
  // R9
  first_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_ev && !exhaust_ev) |=> !first_q);
  // R10
  prime_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_stb && !load_ev && !exhaust_ev) |=> primed_q);
  // R10
  prime_hold_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prime_stb && !wr_stb && !len_wr) |=> $stable(cnt_q));
endmodule

// File: rtl/blit_edge_mask.sv
module blit_edge_mask #(
  parameter int unsigned DATA_W = blit_pkg::BLIT_DATA_W,
  parameter int unsigned LANE_W = blit_pkg::BLIT_LANE_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [DATA_W-1:0]           mask_reg,
  input  logic [DATA_W/LANE_W-1:0]    lane_en,
  input  blit_pkg::blit_dir_e         dir,
  input  logic [$clog2(DATA_W)-1:0]   dst_off,
  input  logic                        first_word,
  input  logic                        cnt_small,
  input  logic [$clog2(DATA_W)-1:0]   cnt_low,
  output logic [DATA_W-1:0]           wmask
);
  localparam int unsigned OFF_W  = $clog2(DATA_W);
  localparam int unsigned NLANES = DATA_W / LANE_W;

  // Tail mask for a short remainder, realigned on the first word.
  function automatic logic [DATA_W-1:0] tail_mask(
    input logic [OFF_W-1:0] n, input blit_pkg::blit_dir_e d,
    input logic first, input logic [OFF_W-1:0] off);
    logic [DATA_W-1:0] m;
    if (d == blit_pkg::BLIT_ASC) begin
      m = ~({DATA_W{1'b1}} << n);
      if (first) m = m << off;
    end else begin
      m = {DATA_W{1'b1}} << (DATA_W - int'(n));
      if (first) m = m >> off;
    end
    return m;
  endfunction

  logic [DATA_W-1:0] lane_bits;
  logic [DATA_W-1:0] base_mask;
  logic [DATA_W-1:0] end_mask;

  for (genvar l = 0; l < NLANES; l++) begin : g_lane
    assign lane_bits[l*LANE_W +: LANE_W] = {LANE_W{lane_en[l]}};
  end

  assign base_mask = mask_reg & lane_bits;
  assign end_mask  = cnt_small ? tail_mask(cnt_low, dir, first_word, dst_off)
                               : {DATA_W{1'b1}};
  assign wmask     = base_mask & end_mask;

  // R2
  mask_within_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wmask & ~(mask_reg & lane_bits)) == '0);
  // R2
  long_span_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_small |-> (wmask == (mask_reg & lane_bits)));
  // R3
  asc_top_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_small && !first_word && dir == blit_pkg::BLIT_ASC) |-> !wmask[DATA_W-1]);
  // R4
  desc_bottom_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_small && !first_word && dir == blit_pkg::BLIT_DESC) |-> !wmask[0]);
endmodule

// File: rtl/blit_edge_ctl.sv
module blit_edge_ctl #(
  parameter int unsigned LEN_W  = blit_pkg::BLIT_LEN_W,
  parameter int unsigned DATA_W = blit_pkg::BLIT_DATA_W,
  parameter int unsigned LANE_W = blit_pkg::BLIT_LANE_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      len_wr,
  input  logic [LEN_W-1:0]          len_val,
  input  logic                      dir_desc,
  input  logic [$clog2(DATA_W)-1:0] dst_off,
  input  logic [DATA_W-1:0]         mask_reg,
  input  logic [DATA_W/LANE_W-1:0]  lane_en,
  input  logic                      wr_stb,
  input  logic                      prime_stb,
  output logic [DATA_W-1:0]         wmask,
  output logic                      first_word,
  output logic                      primed,
  output logic                      done
);
  localparam int unsigned OFF_W = $clog2(DATA_W);

  logic                byte_acc;
  logic                cnt_small;
  logic [OFF_W-1:0]    cnt_low;
  blit_pkg::blit_dir_e dir;

  assign byte_acc = ~&lane_en;
  assign dir      = blit_pkg::blit_dir_e'(dir_desc);

  blit_len_ctr #(.LEN_W(LEN_W), .DATA_W(DATA_W), .LANE_W(LANE_W)) u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .len_wr    (len_wr),
    .len_val   (len_val),
    .wr_stb    (wr_stb),
    .prime_stb (prime_stb),
    .byte_acc  (byte_acc),
    .dst_off   (dst_off),
    .first_q   (first_word),
    .primed_q  (primed),
    .done_q    (done),
    .cnt_small (cnt_small),
    .cnt_low   (cnt_low)
  );

  blit_edge_mask #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_mask (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_reg   (mask_reg),
    .lane_en    (lane_en),
    .dir        (dir),
    .dst_off    (dst_off),
    .first_word (first_word),
    .cnt_small  (cnt_small),
    .cnt_low    (cnt_low),
    .wmask      (wmask)
  );

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> first_word);
endmodule

// File: tb/test_blit_edge_ctl.sv
module test_blit_edge_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_wr = 1'b0;
  logic [11:0] len_val = '0;
  logic        dir_desc = 1'b0;
  logic [3:0]  dst_off = '0;
  logic [15:0] mask_reg = 16'hFFFF;
  logic [1:0]  lane_en = 2'b11;
  logic        wr_stb = 1'b0;
  logic        prime_stb = 1'b0;
  logic [15:0] wmask;
  logic        first_word, primed, done;

  int checks = 0;
  int failures = 0;

  // reference state
  int m_len = 0, m_cnt = 1;
  bit m_first = 1, m_primed = 0, m_done = 0;

  always #4 clk = ~clk;

  blit_edge_ctl i_blit_edge_ctl (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_val(len_val),
    .dir_desc(dir_desc), .dst_off(dst_off), .mask_reg(mask_reg),
    .lane_en(lane_en), .wr_stb(wr_stb), .prime_stb(prime_stb),
    .wmask(wmask), .first_word(first_word), .primed(primed), .done(done)
  );

  function automatic logic [15:0] ref_mask(int cnt, bit first, bit desc, int off,
                                           logic [15:0] mr, logic [1:0] ln);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) begin
      bit ok;
      if (cnt >= 16) ok = 1;
      else if (!desc) ok = first ? (i >= off && i < off + cnt) : (i < cnt);
      else ok = first ? (i >= 16 - cnt - off && i <= 15 - off) : (i >= 16 - cnt);
      r[i] = mr[i] & ln[i / 8] & ok;
    end
    return r;
  endfunction

  function automatic string mask_tag(bit desc);
    if (m_cnt >= 16) return "R2";
    if (m_first) return "R5";
    return desc ? "R4" : "R3";
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    logic [15:0] em;
    em = ref_mask(m_cnt, m_first, dir_desc, int'(dst_off), mask_reg, lane_en);
    chk({tag, "/", mask_tag(dir_desc)}, "wmask", int'(wmask), int'(em));
    chk({tag, "/R9"}, "first_word", int'(first_word), int'(m_first));
    chk({tag, "/R10"}, "primed", int'(primed), int'(m_primed));
    chk({tag, "/R8"}, "done", int'(done), int'(m_done));
  endtask

  task automatic model_edge();
    int d;
    bit is_byte;
    m_done = 0;
    if (len_wr) begin
      m_len = int'(len_val); m_cnt = m_len + 1; m_first = 1; m_primed = 0;
    end else begin
      if (prime_stb) m_primed = 1;
      if (wr_stb) begin
        is_byte = (lane_en != 2'b11);
        if (is_byte) d = m_first ? 8 - (int'(dst_off) % 8) : 8;
        else         d = m_first ? 16 - int'(dst_off) : 16;
        m_cnt -= d;
        if (m_cnt <= 0) begin
          m_cnt = m_len + 1; m_first = 1; m_primed = 0; m_done = 1;
        end else m_first = 0;
      end
    end
  endtask

  // called at a falling edge
  task automatic step(string tag, bit ld, int lv, bit desc, int off,
                      logic [15:0] mr, logic [1:0] ln, bit wr, bit pr);
    len_wr = ld; len_val = 12'(lv); dir_desc = desc; dst_off = 4'(off);
    mask_reg = mr; lane_en = ln; wr_stb = wr; prime_stb = pr;
    #1;
    compare(tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    len_wr = 0; wr_stb = 0; prime_stb = 0;
  endtask

  initial begin
    #(200000 * 8);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    repeat (3) @(negedge clk);
    // R11 reset values seen at the outputs
    compare("R11");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R11");

    // R1 load, then R7 word writes, R2 full masks, R8 reload
    step("R1", 1, 63, 0, 0, 16'hFFFF, 2'b11, 0, 0);
    step("R1", 0, 0, 0, 0, 16'hF7EF, 2'b11, 0, 0);
    for (int k = 0; k < 4; k++) step("R7", 0, 0, 0, 0, 16'hF7EF, 2'b11, 1, 0);
    step("R8", 0, 0, 0, 0, 16'hFFFF, 2'b11, 0, 0);

    // R7 first-word offset, R3 ascending tail
    step("R1", 1, 39, 0, 5, 16'hFFFF, 2'b11, 0, 0);
    for (int k = 0; k < 3; k++) step("R7", 0, 0, 0, 5, 16'hFFFF, 2'b11, 1, 0);
    step("R3", 0, 0, 0, 5, 16'hFFFF, 2'b11, 0, 0);

    // R4 descending tail
    step("R1", 1, 19, 1, 0, 16'hFFFF, 2'b11, 0, 0);
    step("R4", 0, 0, 1, 0, 16'hFFFF, 2'b11, 1, 0);
    step("R4", 0, 0, 1, 0, 16'hFFFF, 2'b11, 0, 0);
    step("R4", 0, 0, 1, 0, 16'hFFFF, 2'b11, 1, 0);

    // R5 short spans shifted on the first word
    step("R1", 1, 9, 0, 3, 16'hFFFF, 2'b11, 0, 0);
    step("R5", 0, 0, 0, 3, 16'hFFFF, 2'b11, 1, 0);
    step("R1", 1, 4, 1, 2, 16'hFFFF, 2'b11, 0, 0);
    step("R5", 0, 0, 1, 2, 16'hFFFF, 2'b11, 1, 0);
    step("R1", 1, 11, 0, 9, 16'hFFFF, 2'b11, 0, 0);
    step("R5", 0, 0, 0, 9, 16'hFFFF, 2'b11, 1, 0);

    // R6 byte-wide writes
    step("R1", 1, 31, 0, 10, 16'hFFFF, 2'b01, 0, 0);
    for (int k = 0; k < 5; k++) step("R6", 0, 0, 0, 10, 16'hFFFF, 2'b01, 1, 0);
    step("R6", 0, 0, 0, 10, 16'hFFFF, 2'b10, 0, 0);

    // R10 priming, cleared by reload and by load
    step("R1", 1, 20, 0, 0, 16'hFFFF, 2'b11, 0, 0);
    step("R10", 0, 0, 0, 0, 16'hFFFF, 2'b11, 0, 1);
    step("R10", 0, 0, 0, 0, 16'hFFFF, 2'b11, 1, 0);
    step("R10", 0, 0, 0, 0, 16'hFFFF, 2'b11, 1, 1);
    step("R10", 0, 0, 0, 0, 16'hFFFF, 2'b11, 0, 1);
    step("R10", 1, 20, 0, 0, 16'hFFFF, 2'b11, 0, 1);
    step("R10", 0, 0, 0, 0, 16'hFFFF, 2'b11, 0, 0);

    // mixed sweep over all modes (R2 to R10)
    lf = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step("R2", (lf[7:0] == 8'h5A), int'(lf[15:4]) % 70, lf[1], int'(lf[11:8]),
           lf ^ 16'h0F0F, (lf[3:2] == 2'b00) ? 2'b11 : lf[3:2], lf[0] | lf[5], lf[6] & lf[9]);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule